// File: doc/BRIEF.md
# Classic Bus Master Engine

This block turns simple local requests into classic, non-pipelined bus cycles on the shared-bus protocol widely known as Wishbone. A request names a direction, a start address, a byte-lane mask and a beat count. The engine raises CYC and STB, holds address, direction, lane mask and write data steady until the slave acknowledges, and then lowers STB for the next cycle. It treats every acknowledge as a single-cycle pulse. It never waits for the acknowledge to fall before it continues.

A block request keeps CYC high for all of its beats. Between two beats, STB goes low for exactly one cycle. Write data is pulled from a local source, one word per beat, and a one-cycle pop strobe tells the source to advance. Read data captured on each completing edge comes back on a local response port. Every bus output is driven from a register. Every bus input is sampled on the rising clock edge.

A generate-time option selects how the address moves across a block. It can advance by a fixed byte step per beat, or it can stay fixed so that a single data port is read or written repeatedly.

Top module: `bus_std_master`

## Requirements
- R1: An active-high `rst` sampled on a rising edge clears `m_cyc`, `m_stb`, `rsp_valid` and `wd_pop` in the next cycle and abandons any block in progress. After reset is released, `cmd_ready` is 1.
- R2: `cmd_ready` is 1 only while no bus cycle is open (`m_cyc` low). A request is taken on an edge where `cmd_valid` and `cmd_ready` are both 1. `m_cyc` and `m_stb` are both 1 in the cycle after that edge.
- R3: A beat completes on a rising edge where `m_cyc`, `m_stb` and `m_ack` are all 1. In the next cycle `m_stb` is 0. An `m_ack` seen while `m_stb` is low produces no beat and no response.
- R4: A request with `cmd_len` = L performs L+1 beats. `m_cyc` stays 1 from the first beat through the last completing edge. Between beats `m_stb` is 0 for exactly one cycle, and `m_cyc` falls in the cycle after the last completion.
- R5: With `ADDR_INCR` = 1, beat k of a block presents `cmd_addr` + k*`ADDR_STEP` on `m_adr`. With `ADDR_INCR` = 0, every beat presents `cmd_addr`.
- R6: If the slave answers combinationally, a single transfer keeps `m_cyc` high for exactly one cycle (two edges from request to completion). If the slave answers from a register after W wait cycles, each beat holds `m_stb` for W+2 cycles. A block of N beats then keeps `m_cyc` high for N*(W+2)+(N-1) cycles.
- R7: On a read beat, `m_dat_i` is captured on the completing edge. It appears on `rsp_data` with `rsp_valid` high for exactly the next cycle.
- R8: While `m_stb` is 1 and no acknowledge has arrived, `m_adr`, `m_we`, `m_sel` and `m_dat_o` keep their values into the next cycle, and `m_stb` stays 1.
- R9: For each write beat, `m_dat_o` carries the `wd_data` value sampled on the edge that raised `m_stb`. `wd_pop` is 1 for that one cycle only, and only when `m_stb` has just risen with `m_we` = 1.
- R10: `m_we` equals `cmd_write` and `m_sel` equals `cmd_sel` of the accepted request on every beat of its block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Engine idle, request can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Number of beats minus one |
| cmd_sel | input | DATA_W/8 | Byte-lane mask for all beats |
| wd_data | input | DATA_W | Next write word from the local source |
| wd_pop | output | 1 | Write word taken, source advances |
| rsp_valid | output | 1 | Read data valid, one cycle per read beat |
| rsp_data | output | DATA_W | Read data |
| m_cyc | output | 1 | Bus cycle open |
| m_stb | output | 1 | Beat strobe |
| m_adr | output | ADDR_W | Bus address |
| m_we | output | 1 | Bus write enable |
| m_sel | output | DATA_W/8 | Bus byte lanes |
| m_dat_o | output | DATA_W | Bus write data |
| m_ack | input | 1 | Slave acknowledge |
| m_dat_i | input | DATA_W | Bus read data |

## Verification
The engine is driven against two slave behaviours. One acknowledges combinationally. The other acknowledges from a register after zero or two wait cycles. The total CYC-high length then separates the one-cycle turnaround from the two-cycle one, and a master that waits for ACK to fall before continuing would add cycles. Single reads and writes are compared with multi-beat blocks. This shows that STB drops for exactly one cycle while CYC stays high, and that addresses and write words advance once per beat and not once per cycle. A reset in the middle of a block, a stray acknowledge while idle, and a second instance with a fixed address check the abort path, the rule that ACK without STB has no effect, and the non-incrementing variant.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
   typedef enum logic [1:0] {
      BSM_IDLE = 2'd0,
      BSM_BEAT = 2'd1,
      BSM_GAP  = 2'd2
   } bsm_state_e;
endpackage

// File: rtl/bsm_beat_ctr.sv
module bsm_beat_ctr #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             dec,
   output logic             last
);
   logic [LEN_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= load_val;
      end else if (dec) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign last = (left_q == '0);
endmodule

// File: rtl/bsm_addr_gen.sv
module bsm_addr_gen #(
   parameter int ADDR_W    = 32,
   parameter int ADDR_STEP = 4,
   parameter bit ADDR_INCR = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              adv,
   output logic [ADDR_W-1:0] adr
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(ADDR_STEP);

   logic [ADDR_W-1:0] adr_q;

   generate
      if (ADDR_INCR) begin : g_incr
         always_ff @(posedge clk) begin
            if (rst) begin
               adr_q <= '0;
            end else if (load) begin
               adr_q <= base;
            end else if (adv) begin
               adr_q <= adr_q + STEP_V;
            end
         end
      end else begin : g_fixed
         always_ff @(posedge clk) begin
            if (rst) begin
               adr_q <= '0;
            end else if (load) begin
               adr_q <= base;
            end
         end
         logic unused_adv;
         assign unused_adv = adv;
      end
   endgenerate

   assign adr = adr_q;
endmodule

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
   import bsm_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic cmd_valid,
   input  logic ack,
   input  logic last,
   output logic cmd_ready,
   output logic accept,
   output logic done,
   output logic restart,
   output logic cyc,
   output logic stb
);
   bsm_state_e state_q;
   logic       cyc_q;
   logic       stb_q;

   assign cmd_ready = (state_q == BSM_IDLE);
   assign accept    = cmd_valid && (state_q == BSM_IDLE);
   assign done      = (state_q == BSM_BEAT) && ack;
   assign restart   = (state_q == BSM_GAP);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= BSM_IDLE;
         cyc_q   <= 1'b0;
         stb_q   <= 1'b0;
      end else begin
         case (state_q)
            BSM_IDLE: begin
               if (cmd_valid) begin
                  state_q <= BSM_BEAT;
                  cyc_q   <= 1'b1;
                  stb_q   <= 1'b1;
               end
            end
            BSM_BEAT: begin
               if (ack) begin
                  stb_q <= 1'b0;
                  if (last) begin
                     cyc_q   <= 1'b0;
                     state_q <= BSM_IDLE;
                  end else begin
                     state_q <= BSM_GAP;
                  end
               end
            end
            BSM_GAP: begin
               stb_q   <= 1'b1;
               state_q <= BSM_BEAT;
            end
            default: begin
               state_q <= BSM_IDLE;
               cyc_q   <= 1'b0;
               stb_q   <= 1'b0;
            end
         endcase
      end
   end

   assign cyc = cyc_q;
   assign stb = stb_q;
endmodule

// File: rtl/bus_std_master.sv
module bus_std_master #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int LEN_W     = 8,
   parameter int ADDR_STEP = DATA_W / 8,
   parameter bit ADDR_INCR = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cmd_valid,
   output logic                  cmd_ready,
   input  logic                  cmd_write,
   input  logic [ADDR_W-1:0]     cmd_addr,
   input  logic [LEN_W-1:0]      cmd_len,
   input  logic [DATA_W/8-1:0]   cmd_sel,
   input  logic [DATA_W-1:0]     wd_data,
   output logic                  wd_pop,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_data,
   output logic                  m_cyc,
   output logic                  m_stb,
   output logic [ADDR_W-1:0]     m_adr,
   output logic                  m_we,
   output logic [DATA_W/8-1:0]   m_sel,
   output logic [DATA_W-1:0]     m_dat_o,
   input  logic                  m_ack,
   input  logic [DATA_W-1:0]     m_dat_i
);
   localparam int SEL_W = DATA_W / 8;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data_w
         $error("bus_std_master: DATA_W must be a positive multiple of 8");
      end
      if (LEN_W < 1) begin : g_bad_len_w
         $error("bus_std_master: LEN_W must be at least 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("bus_std_master: ADDR_W must be at least 2");
      end
      if (ADDR_STEP < 1) begin : g_bad_step
         $error("bus_std_master: ADDR_STEP must be at least 1");
      end
   endgenerate

   logic accept;
   logic done;
   logic restart;
   logic last;

   bsm_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .cmd_valid (cmd_valid),
      .ack       (m_ack),
      .last      (last),
      .cmd_ready (cmd_ready),
      .accept    (accept),
      .done      (done),
      .restart   (restart),
      .cyc       (m_cyc),
      .stb       (m_stb)
   );

   bsm_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (accept),
      .load_val (cmd_len),
      .dec      (done && !last),
      .last     (last)
   );

   bsm_addr_gen #(
      .ADDR_W    (ADDR_W),
      .ADDR_STEP (ADDR_STEP),
      .ADDR_INCR (ADDR_INCR)
   ) u_adr (
      .clk  (clk),
      .rst  (rst),
      .load (accept),
      .base (cmd_addr),
      .adv  (done && !last),
      .adr  (m_adr)
   );

   logic              we_q;
   logic [SEL_W-1:0]  sel_q;
   logic [DATA_W-1:0] dat_q;
   logic              pop_q;
   logic              rv_q;
   logic [DATA_W-1:0] rd_q;
   logic              take_wd;

   assign take_wd = (accept && cmd_write) || (restart && we_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         we_q  <= 1'b0;
         sel_q <= '0;
         dat_q <= '0;
         pop_q <= 1'b0;
         rv_q  <= 1'b0;
         rd_q  <= '0;
      end else begin
         if (accept) begin
            we_q  <= cmd_write;
            sel_q <= cmd_sel;
         end
         if (take_wd) begin
            dat_q <= wd_data;
         end
         pop_q <= take_wd;
         rv_q  <= done && !we_q;
         if (done && !we_q) begin
            rd_q <= m_dat_i;
         end
      end
   end

   assign m_we      = we_q;
   assign m_sel     = sel_q;
   assign m_dat_o   = dat_q;
   assign wd_pop    = pop_q;
   assign rsp_valid = rv_q;
   assign rsp_data  = rd_q;
endmodule

// File: rtl/bsm_chk.sv
module bsm_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic                clk,
   input logic                rst,
   input logic                cmd_ready,
   input logic                wd_pop,
   input logic                rsp_valid,
   input logic                m_cyc,
   input logic                m_stb,
   input logic [ADDR_W-1:0]   m_adr,
   input logic                m_we,
   input logic [DATA_W/8-1:0] m_sel,
   input logic [DATA_W-1:0]   m_dat_o,
   input logic                m_ack
);
   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (!m_cyc && !m_stb && !rsp_valid && !wd_pop));

   // R2
   ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
      cmd_ready |-> !m_cyc);

   // R3
   stb_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (m_cyc && m_stb && m_ack) |=> !m_stb);

   // R4
   stb_in_cyc_chk: assert property (@(posedge clk) disable iff (rst)
      m_stb |-> m_cyc);

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (m_stb && !m_ack) |=> (m_stb && $stable(m_adr) && $stable(m_we)
                             && $stable(m_sel) && $stable(m_dat_o)));

   // R7
   rsp_src_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> $past(m_cyc && m_stb && m_ack && !m_we));

   // R9
   pop_chk: assert property (@(posedge clk) disable iff (rst)
      wd_pop |-> (m_stb && m_we && $rose(m_stb)));
endmodule

bind bus_std_master bsm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cmd_ready (cmd_ready),
   .wd_pop    (wd_pop),
   .rsp_valid (rsp_valid),
   .m_cyc     (m_cyc),
   .m_stb     (m_stb),
   .m_adr     (m_adr),
   .m_we      (m_we),
   .m_sel     (m_sel),
   .m_dat_o   (m_dat_o),
   .m_ack     (m_ack)
);

// File: tb/sim_bus_std_master.sv
module sim_bus_std_master;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int LW = 8;
   localparam int SW = DW / 8;

   typedef struct packed {
      logic [AW-1:0] adr;
      logic          we;
      logic [SW-1:0] sel;
      logic [DW-1:0] dat;
      logic          last;
   } beat_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic          cmd_write = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [LW-1:0] cmd_len = '0;
   logic [SW-1:0] cmd_sel = '0;
   logic [DW-1:0] wd_data;
   logic          wd_pop;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          m_cyc, m_stb, m_we, m_ack;
   logic [AW-1:0] m_adr;
   logic [SW-1:0] m_sel;
   logic [DW-1:0] m_dat_o, m_dat_i;

   int checks = 0;
   int fails  = 0;

   // slave model
   logic slv_comb = 1'b1;
   int   slv_wait = 0;
   logic stray = 1'b0;
   logic ack_q = 1'b0;
   int   wcnt = 0;

   always @(posedge clk) begin
      if (rst) begin
         ack_q <= 1'b0;
         wcnt  <= 0;
      end else if (ack_q) begin
         ack_q <= 1'b0;
      end else if (m_cyc && m_stb && !slv_comb) begin
         if (wcnt == slv_wait) begin
            ack_q <= 1'b1;
            wcnt  <= 0;
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   function automatic logic [DW-1:0] rd_val(logic [AW-1:0] a);
      return a ^ 32'hA5A5_0000;
   endfunction

   function automatic logic [DW-1:0] wr_val(int i);
      return 32'h1000_0000 + DW'(i * 3);
   endfunction

   assign m_ack   = (slv_comb ? (m_cyc && m_stb) : ack_q) | stray;
   assign m_dat_i = rd_val(m_adr);

   // write data source
   int wptr = 0;
   int wexp = 0;
   always @(posedge clk) if (wd_pop) wptr <= wptr + 1;
   assign wd_data = wr_val(wptr);

   bus_std_master #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) u0 (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
      .cmd_sel(cmd_sel), .wd_data(wd_data), .wd_pop(wd_pop),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .m_cyc(m_cyc),
      .m_stb(m_stb), .m_adr(m_adr), .m_we(m_we), .m_sel(m_sel),
      .m_dat_o(m_dat_o), .m_ack(m_ack), .m_dat_i(m_dat_i)
   );

   // fixed-address variant
   logic          f_valid = 1'b0;
   logic          f_ready, f_pop, f_rv, f_cyc, f_stb, f_we;
   logic [DW-1:0] f_rd, f_dato;
   logic [AW-1:0] f_adr;
   logic [SW-1:0] f_sel;
   bus_std_master #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .ADDR_INCR(1'b0)) u1 (
      .clk(clk), .rst(rst), .cmd_valid(f_valid), .cmd_ready(f_ready),
      .cmd_write(1'b0), .cmd_addr(32'h0000_0040), .cmd_len(8'd2),
      .cmd_sel(4'hF), .wd_data(32'h0), .wd_pop(f_pop),
      .rsp_valid(f_rv), .rsp_data(f_rd), .m_cyc(f_cyc),
      .m_stb(f_stb), .m_adr(f_adr), .m_we(f_we), .m_sel(f_sel),
      .m_dat_o(f_dato), .m_ack(f_cyc && f_stb), .m_dat_i(rd_val(f_adr))
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // scoreboard
   beat_t         exp_q[$];
   logic [DW-1:0] rsp_q[$];
   int            exp_len = 0;
   bit            len_skip = 1'b0;
   int            cyc_cnt = 0;
   bit            gap_pend = 1'b0;
   bit            gap_more = 1'b0;
   bit            prev_hold = 1'b0;
   beat_t         snap;

   always @(negedge clk) begin
      if (rst) begin
         gap_pend  = 1'b0;
         prev_hold = 1'b0;
         cyc_cnt   = 0;
      end else begin
         if (rsp_valid) begin
            if (rsp_q.size() == 0) begin
               check(1'b0, "R7", "unexpected rsp_valid", 64'(rsp_data), 64'h0);
            end else begin
               logic [DW-1:0] e;
               e = rsp_q.pop_front();
               check(rsp_data == e, "R7", "rsp_data", 64'(rsp_data), 64'(e));
            end
         end
         if (gap_pend) begin
            // R3 R4: stb low one cycle, cyc held only if beats remain
            check(!m_stb, "R3", "stb after ack", 64'(m_stb), 64'h0);
            check(m_cyc == gap_more, "R4", "cyc after beat", 64'(m_cyc), 64'(gap_more));
            gap_pend = 1'b0;
         end
         if (prev_hold && m_stb) begin
            check(m_adr == snap.adr && m_we == snap.we && m_sel == snap.sel &&
                  m_dat_o == snap.dat, "R8", "hold while waiting",
                  64'(m_adr), 64'(snap.adr));
         end
         prev_hold = m_stb && !m_ack;
         snap = '{adr: m_adr, we: m_we, sel: m_sel, dat: m_dat_o, last: 1'b0};
         if (m_cyc && m_stb && m_ack) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R4", "extra beat", 64'(m_adr), 64'h0);
            end else begin
               beat_t e;
               e = exp_q.pop_front();
               check(m_adr == e.adr, "R5", "beat address", 64'(m_adr), 64'(e.adr));
               check(m_we == e.we && m_sel == e.sel, "R10", "we/sel",
                     64'({m_we, m_sel}), 64'({e.we, e.sel}));
               if (e.we)
                  check(m_dat_o == e.dat, "R9", "write data", 64'(m_dat_o), 64'(e.dat));
               else
                  rsp_q.push_back(rd_val(e.adr));
               gap_pend = 1'b1;
               gap_more = !e.last;
            end
         end
         if (m_cyc) begin
            cyc_cnt++;
         end else if (cyc_cnt > 0) begin
            if (!len_skip)
               check(cyc_cnt == exp_len, "R6", "cyc high cycles",
                     64'(cyc_cnt), 64'(exp_len));
            cyc_cnt = 0;
         end
      end
   end

   task automatic issue(input bit wr, input logic [AW-1:0] a,
                        input int len, input logic [SW-1:0] sel);
      int n;
      int per;
      n   = len + 1;
      per = slv_comb ? 1 : (slv_wait + 2);
      exp_len = n * per + (n - 1);
      for (int i = 0; i < n; i++) begin
         beat_t b;
         b.adr  = a + AW'(4 * i);
         b.we   = wr;
         b.sel  = sel;
         b.dat  = wr ? wr_val(wexp) : '0;
         b.last = (i == len);
         if (wr) wexp++;
         exp_q.push_back(b);
      end
      @(posedge clk); #1;
      while (!cmd_ready) begin @(posedge clk); #1; end
      cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a;
      cmd_len = LW'(len); cmd_sel = sel;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
      // R2: cycle opens right after acceptance
      check(m_cyc && m_stb, "R2", "cyc/stb after accept", 64'({m_cyc, m_stb}), 64'h3);
      do @(negedge clk); while (exp_q.size() != 0 || rsp_q.size() != 0 || m_cyc);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      check(!m_cyc && !m_stb && !rsp_valid && !wd_pop && cmd_ready, "R1",
            "reset state", 64'({m_cyc, m_stb, rsp_valid, wd_pop, cmd_ready}), 64'h1);

      // combinational slave
      slv_comb = 1'b1;
      issue(1'b1, 32'h0000_1000, 0, 4'hF);   // R6 single write, 1 cycle
      issue(1'b0, 32'h0000_2000, 0, 4'h3);   // R7 single read
      issue(1'b1, 32'h0000_3000, 3, 4'hC);   // R4 R9 block write
      issue(1'b0, 32'h0000_4000, 4, 4'hF);   // R4 R7 block read

      // registered slave, no wait and with waits
      slv_comb = 1'b0; slv_wait = 0;
      issue(1'b0, 32'h0000_5000, 0, 4'hF);
      issue(1'b1, 32'h0000_6000, 2, 4'h5);
      slv_wait = 2;
      issue(1'b0, 32'h0000_7000, 2, 4'hA);   // R8 holds during waits
      issue(1'b1, 32'h0000_8000, 1, 4'hF);

      // R3: stray ack with no strobe
      @(posedge clk); #1 stray = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(!rsp_valid && !m_cyc && !m_stb, "R3", "stray ack ignored",
               64'({rsp_valid, m_cyc, m_stb}), 64'h0);
      end
      @(posedge clk); #1 stray = 1'b0;

      // R1: reset in the middle of a block
      len_skip = 1'b1;
      slv_wait = 0;
      for (int i = 0; i < 6; i++) begin
         beat_t b;
         b = '{adr: 32'h0000_9000 + 32'(4 * i), we: 1'b0, sel: 4'hF, dat: '0, last: (i == 5)};
         exp_q.push_back(b);
      end
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 32'h0000_9000;
      cmd_len = 8'd5; cmd_sel = 4'hF;
      @(posedge clk); #1 cmd_valid = 1'b0;
      while (exp_q.size() > 4) begin @(posedge clk); #1; end
      rst = 1'b1;
      @(posedge clk); #1;
      rst = 1'b0;
      exp_q.delete(); rsp_q.delete();
      @(negedge clk);
      check(!m_cyc && !m_stb && cmd_ready, "R1", "abort clears bus",
            64'({m_cyc, m_stb, cmd_ready}), 64'h1);
      repeat (3) begin
         @(negedge clk);
         check(!m_cyc && !rsp_valid, "R1", "stays idle after abort",
               64'({m_cyc, rsp_valid}), 64'h0);
      end
      len_skip = 1'b0;
      wexp = wptr;
      slv_comb = 1'b1;
      issue(1'b1, 32'h0000_A000, 1, 4'hF);   // recovery after abort

      // R5: fixed-address variant
      @(posedge clk); #1 f_valid = 1'b1;
      @(posedge clk); #1 f_valid = 1'b0;
      begin
         int nb;
         nb = 0;
         for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (f_stb) begin
               nb++;
               check(f_adr == 32'h0000_0040, "R5", "fixed address",
                     64'(f_adr), 64'h40);
            end
         end
         check(nb == 3, "R5", "fixed-address beat count", 64'(nb), 64'd3);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule